// File: doc/BRIEF.md
# Video and Audio InfoFrame Packet Generator

This block holds two small side-channel packets for a display output, one describing the video (auxiliary video information) and one describing the audio. Each packet is three header bytes, a checksum byte and up to `MAX_PAY` payload bytes. Software, or a configuration engine, fills the header, payload and per-packet enable through a byte-wide register-write port. A separate address writes the video identification code, which is always carried as video payload byte 4. The block computes the checksum itself, so any register change shows up in the next packet with no extra command.

On each rising edge of the vertical sync input the enabled packets go out once, video first and audio second, as a byte stream with valid/ready flow control and a last-byte marker. A rising edge that arrives while a sequence is still running is remembered and served after that sequence ends. When the DVI-mode input is high as a sequence begins, nothing is sent, whatever the enables hold.

Top module: `ifr_pkt_gen`

## Requirements
- R1: After reset `out_valid` is low. The register contents are then: video header 0x82, 0x02, 0x0D; audio header 0x84, 0x01, 0x0A; video payload byte 1 = 0x12 (bit 4 active-format valid, bit 1 underscanned, bits 6:5 = 0 for RGB); video payload byte 2 = 0x28 (bits 5:4 = 2 for 16:9, bits 3:0 = 8 for same-as-picture); every other payload byte 0; both enables clear.
- R2: Write address: bits 6:5 select the target (0 video, 1 audio, 2 video identification code). For targets 0 and 1, offset 0 is the control byte, offsets 1 to 3 are header bytes 0 to 2, and offset 16+n-1 is payload byte n.
- R3: A packet is sent as header byte 0, 1, 2, then the checksum, then payload bytes 1 to N. `out_last` is high on the final byte of each packet only.
- R4: The checksum is the 8-bit two's complement of the sum of the three header bytes and payload bytes 1 to N, so all bytes of a packet sum to 0 modulo 256.
- R5: The payload count N equals header byte 2, clamped to `MAX_PAY`; a length of 0 sends the four leading bytes only.
- R6: Bit 1 of a packet's control byte enables it; the other control bits have no effect.
- R7: A rising edge of `vsync` starts one sequence that sends the enabled video packet and then the enabled audio packet. Holding `vsync` high starts no further sequence.
- R8: If `dvi_mode` is high when a sequence starts, no packet of that sequence is sent.
- R9: A rising edge of `vsync` during a running sequence is held as pending and starts one more sequence after the current one ends.
- R10: A write to target 2 and a write to video payload byte 4 update the same byte, which is sent as video payload byte 4.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address (default `MAX_PAY`) |
| wr_data | input | 8 | Register write data |
| vsync | input | 1 | Vertical sync; rising edge starts a sequence |
| dvi_mode | input | 1 | Suppresses all packets when high at sequence start |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | Byte valid |
| out_last | output | 1 | Final byte of a packet |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
The checksum property assumes that no register is written while a packet is being sent, since header and payload are read live; the stimulus only writes registers after the previous sequence has fully drained. The pending-edge property assumes `vsync` is a level that the block itself samples, and the bench moves it only on falling clock edges. Length sweeps cover every header length from 0 to two past `MAX_PAY`, and backpressure is applied from a pseudo-random ready pattern.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  localparam logic [7:0] TYPE_BASE = 8'h80;
  localparam logic [7:0] TYPE_VID  = TYPE_BASE + 8'h02;
  localparam logic [7:0] TYPE_AUD  = TYPE_BASE + 8'h04;
  localparam logic [7:0] VER_VID   = 8'h02;
  localparam logic [7:0] LEN_VID   = 8'h0D;
  localparam logic [7:0] VER_AUD   = 8'h01;
  localparam logic [7:0] LEN_AUD   = 8'h0A;

  // video payload defaults: byte 1 = active format valid | underscanned, RGB
  localparam logic [7:0] VID_B1_DEF = 8'h12;
  // byte 2 = 16:9 picture aspect, active format same as picture
  localparam logic [7:0] VID_B2_DEF = 8'h28;

  localparam int PK_VID = 0;
  localparam int PK_AUD = 1;
  localparam int NUM_PK = 2;

  localparam int CTRL_TX_BIT = 1;
  localparam int VIC_SLOT    = 3;   // payload byte 4, zero based
  localparam int NUM_HDR     = 3;

  typedef enum logic [1:0] {
    RG_VID  = 2'd0,
    RG_AUD  = 2'd1,
    RG_VIC  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  function automatic logic [7:0] hdr_default(input int p, input int i);
    logic [7:0] v;
    v = 8'h00;
    if (p == PK_VID) begin
      case (i)
        0:       v = TYPE_VID;
        1:       v = VER_VID;
        default: v = LEN_VID;
      endcase
    end else begin
      case (i)
        0:       v = TYPE_AUD;
        1:       v = VER_AUD;
        default: v = LEN_AUD;
      endcase
    end
    return v;
  endfunction

  function automatic logic [7:0] pay_default(input int p, input int i);
    logic [7:0] v;
    v = 8'h00;
    if (p == PK_VID && i == 0) v = VID_B1_DEF;
    if (p == PK_VID && i == 1) v = VID_B2_DEF;
    return v;
  endfunction

endpackage

// File: rtl/ifr_regs.sv
module ifr_regs
  import ifr_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int PI_W    = $clog2(MAX_PAY),
  parameter int OFS_W   = PI_W + 1,
  parameter int ADDR_W  = OFS_W + 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [7:0]                            wr_data,
  output logic [NUM_PK-1:0]                     tx_en,
  output logic [NUM_PK-1:0][NUM_HDR-1:0][7:0]   hdr,
  output logic [NUM_PK-1:0][MAX_PAY-1:0][7:0]   pay
);

  region_e            wr_rg;
  logic [OFS_W-1:0]   ofs;

  assign wr_rg = region_e'(wr_addr[ADDR_W-1 -: 2]);
  assign ofs   = wr_addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_PK; g++) begin : g_pk
    logic                          tx_q;
    logic [NUM_HDR-1:0][7:0]       h_q;
    logic [MAX_PAY-1:0][7:0]       p_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        tx_q <= 1'b0;
        for (int i = 0; i < NUM_HDR; i++) h_q[i] <= hdr_default(g, i);
        for (int i = 0; i < MAX_PAY; i++) p_q[i] <= pay_default(g, i);
      end else if (wr_en) begin
        if (wr_rg == region_e'(g)) begin
          if (ofs == '0)
            tx_q <= wr_data[CTRL_TX_BIT];
          else if (ofs < OFS_W'(NUM_HDR + 1))
            h_q[ofs[1:0] - 2'd1] <= wr_data;
          else if (ofs[OFS_W-1] && (int'(ofs[PI_W-1:0]) < MAX_PAY))
            p_q[ofs[PI_W-1:0]] <= wr_data;
        end
        if (g == PK_VID && wr_rg == RG_VIC)
          p_q[VIC_SLOT] <= wr_data;
      end
    end

    assign tx_en[g] = tx_q;
    assign hdr[g]   = h_q;
    assign pay[g]   = p_q;
  end

endmodule

// File: rtl/ifr_cksum.sv
module ifr_cksum
  import ifr_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = $clog2(MAX_PAY + 1)
) (
  input  logic [NUM_HDR-1:0][7:0]  hdr,
  input  logic [MAX_PAY-1:0][7:0]  pay,
  output logic [LEN_W-1:0]         len_o,
  output logic [7:0]               cks_o
);

  localparam logic [7:0] MAX_B = 8'(MAX_PAY);

  logic [7:0] acc;

  always_comb begin
    if (hdr[2] > MAX_B) len_o = LEN_W'(MAX_PAY);
    else                len_o = hdr[2][LEN_W-1:0];
    acc = hdr[0] + hdr[1] + hdr[2];
    for (int i = 0; i < MAX_PAY; i++) begin
      if (i < int'(len_o)) acc = acc + pay[i];
    end
    cks_o = 8'h00 - acc;
  end

endmodule

// File: rtl/ifr_sched.sv
module ifr_sched
  import ifr_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = $clog2(MAX_PAY + 1),
  parameter int IDX_W   = $clog2(MAX_PAY + 4),
  parameter int PI_W    = $clog2(MAX_PAY)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  vsync,
  input  logic                                  dvi_mode,
  input  logic [NUM_PK-1:0]                     tx_en,
  input  logic [NUM_PK-1:0][NUM_HDR-1:0][7:0]   hdr,
  input  logic [NUM_PK-1:0][MAX_PAY-1:0][7:0]   pay,
  input  logic [NUM_PK-1:0][LEN_W-1:0]          len,
  input  logic [NUM_PK-1:0][7:0]                cks,
  output logic                                  pend_o,
  output logic [7:0]                            out_data,
  output logic                                  out_valid,
  output logic                                  out_last,
  input  logic                                  out_ready
);

  logic               vs_q;
  logic               pend;
  logic               busy;
  logic               pkt;
  logic               both;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   pi;
  logic [NUM_PK-1:0]  go_mask;
  logic               vs_rise;
  logic               load;
  logic               at_end;
  logic [7:0]         cur;

  assign vs_rise = vsync & ~vs_q;
  assign go_mask = tx_en & {NUM_PK{~dvi_mode}};
  assign load    = ~out_valid | out_ready;
  assign at_end  = (idx == (IDX_W'(len[pkt]) + IDX_W'(NUM_HDR)));
  assign pi      = idx - IDX_W'(NUM_HDR + 1);
  assign pend_o  = pend;

  always_comb begin
    cur = 8'h00;
    if (idx < IDX_W'(NUM_HDR))
      cur = hdr[pkt][idx[1:0]];
    else if (idx == IDX_W'(NUM_HDR))
      cur = cks[pkt];
    else if (int'(pi) < MAX_PAY)
      cur = pay[pkt][pi[PI_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= 1'b0;
      pend      <= 1'b0;
      busy      <= 1'b0;
      pkt       <= 1'b0;
      both      <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else begin
      vs_q <= vsync;
      pend <= vs_rise | (pend & busy);
      if (!busy) begin
        if (pend && (go_mask != '0)) begin
          busy <= 1'b1;
          pkt  <= ~go_mask[PK_VID];
          both <= &go_mask;
          idx  <= '0;
        end
      end else if (load) begin
        if (at_end) begin
          if (!pkt && both) begin
            pkt <= 1'b1;
            idx <= '0;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
      if (load) begin
        out_valid <= busy;
        out_data  <= busy ? cur : 8'h00;
        out_last  <= busy & at_end;
      end
    end
  end

endmodule

// File: rtl/ifr_pkt_gen.sv
module ifr_pkt_gen
  import ifr_pkg::*;
#(
  parameter int MAX_PAY = 16,
  localparam int PI_W   = $clog2(MAX_PAY),
  localparam int OFS_W  = PI_W + 1,
  localparam int ADDR_W = OFS_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               vsync,
  input  logic               dvi_mode,
  output logic [7:0]         out_data,
  output logic               out_valid,
  output logic               out_last,
  input  logic               out_ready
);

  localparam int LEN_W = $clog2(MAX_PAY + 1);
  localparam int IDX_W = $clog2(MAX_PAY + 4);

  logic [NUM_PK-1:0]                    tx_en;
  logic [NUM_PK-1:0][NUM_HDR-1:0][7:0]  hdr;
  logic [NUM_PK-1:0][MAX_PAY-1:0][7:0]  pay;
  logic [NUM_PK-1:0][LEN_W-1:0]         len;
  logic [NUM_PK-1:0][7:0]               cks;
  logic                                 seq_pend;

  ifr_regs #(
    .MAX_PAY (MAX_PAY),
    .PI_W    (PI_W),
    .OFS_W   (OFS_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tx_en   (tx_en),
    .hdr     (hdr),
    .pay     (pay)
  );

  for (genvar g = 0; g < NUM_PK; g++) begin : g_ck
    ifr_cksum #(
      .MAX_PAY (MAX_PAY),
      .LEN_W   (LEN_W)
    ) u_ck (
      .hdr   (hdr[g]),
      .pay   (pay[g]),
      .len_o (len[g]),
      .cks_o (cks[g])
    );
  end

  ifr_sched #(
    .MAX_PAY (MAX_PAY),
    .LEN_W   (LEN_W),
    .IDX_W   (IDX_W),
    .PI_W    (PI_W)
  ) u_sched (
    .clk       (clk),
    .rst       (rst),
    .vsync     (vsync),
    .dvi_mode  (dvi_mode),
    .tx_en     (tx_en),
    .hdr       (hdr),
    .pay       (pay),
    .len       (len),
    .cks       (cks),
    .pend_o    (seq_pend),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready)
  );

endmodule

// File: rtl/ifr_pkt_chk.sv
module ifr_pkt_chk #(
  parameter int MAX_PAY = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       vsync,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_ready,
  input logic       seq_pend
);

  localparam int CW = $clog2(MAX_PAY + 5);

  logic [7:0]    acc;
  logic [CW-1:0] cnt;
  logic          vs_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= 8'h00;
      cnt     <= '0;
      vs_seen <= 1'b0;
    end else begin
      vs_seen <= vsync;
      if (out_valid && out_ready) begin
        if (out_last) begin
          acc <= 8'h00;
          cnt <= '0;
        end else begin
          acc <= acc + out_data;
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R11: held byte while the sink stalls
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R3: the end marker only accompanies a valid byte
  a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R4: bytes of every packet sum to zero
  a_r4_sum_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> ((acc + out_data) == 8'h00));

  // R5: packet never longer than header, checksum and full payload
  a_r5_max_len: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (cnt < CW'(MAX_PAY + 4)));

  // R9: a sync edge is always remembered
  a_r9_pending: assert property (@(posedge clk) disable iff (rst)
    (vsync && !vs_seen) |=> seq_pend);

endmodule

bind ifr_pkt_gen ifr_pkt_chk #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vsync     (vsync),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_ready (out_ready),
  .seq_pend  (seq_pend)
);

// File: tb/sim_ifr_pkt_gen.sv
module sim_ifr_pkt_gen;

  localparam int MAXP = 16;
  localparam int AW   = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic          vsync = 1'b0;
  logic          dvi_mode = 1'b0;
  logic [7:0]    out_data;
  logic          out_valid;
  logic          out_last;
  logic          out_ready = 1'b1;

  always #10 clk = ~clk;

  ifr_pkt_gen #(.MAX_PAY(MAXP)) u0 (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .vsync     (vsync),
    .dvi_mode  (dvi_mode),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  logic [7:0] exp_q[$];
  logic       exp_l[$];
  logic [7:0] got_q[$];
  logic       got_l[$];

  logic [7:0] m_hdr [2][3];
  logic [7:0] m_pay [2][MAXP];
  logic       m_tx  [2];

  bit          rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_rand ? lfsr[0] : 1'b1;
    #1;
    if (out_valid && out_ready) begin
      got_q.push_back(out_data);
      got_l.push_back(out_last);
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    int r;
    int o;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    r = int'(a[6:5]);
    o = int'(a[4:0]);
    if (r < 2) begin
      if (o == 0) m_tx[r] = d[1];
      else if (o <= 3) m_hdr[r][o-1] = d;
      else if (o >= 16) m_pay[r][o-16] = d;
    end else if (r == 2) begin
      m_pay[0][3] = d;
    end
  endtask

  task automatic push_pkt(input int p);
    int n;
    int s;
    n = (int'(m_hdr[p][2]) > MAXP) ? MAXP : int'(m_hdr[p][2]);
    s = int'(m_hdr[p][0]) + int'(m_hdr[p][1]) + int'(m_hdr[p][2]);
    for (int i = 0; i < n; i++) s += int'(m_pay[p][i]);
    for (int i = 0; i < 3; i++) begin exp_q.push_back(m_hdr[p][i]); exp_l.push_back(1'b0); end
    exp_q.push_back(8'((256 - (s % 256)) % 256));
    exp_l.push_back(n == 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_pay[p][i]);
      exp_l.push_back(i == n - 1);
    end
  endtask

  task automatic push_seq();
    if (m_tx[0] && !dvi_mode) push_pkt(0);
    if (m_tx[1] && !dvi_mode) push_pkt(1);
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic compare(input string tag);
    int n;
    int s;
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    chk(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < n; i++) begin
      chk(got_q[i] == exp_q[i], $sformatf("%s byte %0d", tag, i), got_q[i], exp_q[i]);
      chk(got_l[i] == exp_l[i], $sformatf("R3 last %s %0d", tag, i), got_l[i], exp_l[i]);
    end
    s = 0;
    for (int i = 0; i < got_q.size(); i++) begin
      s += int'(got_q[i]);
      if (got_l[i]) begin
        chk((s % 256) == 0, {"R4 sum ", tag}, s % 256, 0);
        s = 0;
      end
    end
    exp_q.delete(); exp_l.delete(); got_q.delete(); got_l.delete();
  endtask

  task automatic run_one(input string tag);
    push_seq();
    pulse();
    repeat (400) @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_tx[p] = 1'b0;
      for (int i = 0; i < MAXP; i++) m_pay[p][i] = 8'h00;
    end
    m_hdr[0][0] = 8'h82; m_hdr[0][1] = 8'h02; m_hdr[0][2] = 8'h0D;
    m_hdr[1][0] = 8'h84; m_hdr[1][1] = 8'h01; m_hdr[1][2] = 8'h0A;
    m_pay[0][0] = 8'h12; m_pay[0][1] = 8'h28;

    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R6: nothing enabled after reset, a sync edge sends nothing
    run_one("R6 idle");

    // R1, R3: video packet with reset contents
    wr(7'h00, 8'h02);
    run_one("R1 video default");

    // R7: both packets, video first
    wr(7'h20, 8'h02);
    wr(7'h10 + 7'h20, 8'h5A);
    wr(7'h19 + 7'h20, 8'hC3);
    run_one("R7 order");

    // R3: audio alone
    wr(7'h00, 8'h00);
    run_one("R3 audio only");

    // R6: only bit 1 enables
    wr(7'h00, 8'hFD);
    wr(7'h20, 8'hFD);
    run_one("R6 other bits");

    // R8: DVI suppresses, then recovers
    wr(7'h00, 8'h02);
    wr(7'h20, 8'h02);
    dvi_mode = 1'b1;
    run_one("R8 dvi");
    dvi_mode = 1'b0;
    run_one("R8 after dvi");

    // R2: header rewrite through the address map
    wr(7'h21, 8'h99);
    wr(7'h22, 8'h07);
    wr(7'h1C, 8'hE1);
    run_one("R2 map");

    // R5: length sweep on audio
    wr(7'h00, 8'h00);
    for (int L = 0; L <= MAXP + 2; L++) begin
      wr(7'h30 + 7'(L % MAXP), 8'((L * 37 + 5) % 256));
      wr(7'h23, 8'(L));
      run_one($sformatf("R5 len %0d", L));
    end

    // R10: identification code aliasing
    wr(7'h00, 8'h02);
    wr(7'h20, 8'h00);
    wr(7'h40, 8'd31);
    run_one("R10 code reg");
    wr(7'h13, 8'd4);
    run_one("R10 payload slot");

    // R9: edge during a sequence is not lost
    wr(7'h20, 8'h02);
    push_seq();
    push_seq();
    pulse();
    repeat (4) @(negedge clk);
    pulse();
    repeat (400) @(negedge clk);
    compare("R9 pending");

    // R7: held sync triggers once
    push_seq();
    @(negedge clk); vsync = 1'b1;
    repeat (400) @(negedge clk);
    vsync = 1'b0;
    repeat (20) @(negedge clk);
    compare("R7 held");

    // R11: random backpressure
    rdy_rand = 1'b1;
    run_one("R11 stall");
    run_one("R11 stall again");
    rdy_rand = 1'b0;

    summary();
    $finish;
  end

endmodule